// File: doc/BRIEF.md
# Registered bidirectional bus transceiver

This block links two tri-state buses, A and B, of a parameterized width (8 bits by default). Each direction has its own storage register with its own rising-edge clock. Each also has a select that decides whether the far bus is driven with the live pin values or with the stored word. Either register samples its source bus on every rising edge of its clock, whatever the drive settings. That lets a system snoop, latch and later replay bus traffic in either direction.

Two output enables, of opposite polarity, gate the drivers. The B-side enable is active-high and the A-side enable is active-low. Together they give isolation, transfer in one direction, or a swap in which both buses show stored data at once. When one bus is driven live from the other, clocking both registers on the same edge loads one word into both of them. When the driven side shows stored data, the two clocks have to be staggered.

The case where both drivers are enabled and both selects choose live data forms a loop between the buses. It is forbidden and is flagged by an assertion.

Top module: `dual_bus_xcvr`

## Requirements
- R1: While `oe_b` is 0 the block does not drive `bus_b`; when `oe_b` is 1 it drives `bus_b`.
- R2: While `oe_a_n` is 1 the block does not drive `bus_a`; when `oe_a_n` is 0 it drives `bus_a`.
- R3: With `oe_b`=0 and `oe_a_n`=1 both buses are inputs only, and both stored words are unchanged while neither clock rises.
- R4: On every rising edge of `clk_ab` the A-to-B register takes the value on the `bus_a` pins, regardless of enables and selects.
- R5: On every rising edge of `clk_ba` the B-to-A register takes the value on the `bus_b` pins, regardless of enables and selects.
- R6: With `oe_b`=1 and `sel_ab`=0, `bus_b` follows the live `bus_a` pin values.
- R7: With `oe_b`=1 and `sel_ab`=1, `bus_b` shows the A-to-B register.
- R8: With `oe_a_n`=0 and `sel_ba`=0, `bus_a` follows the live `bus_b` pin values. Enabling both drivers with both selects at 0 is forbidden.
- R9: With `oe_a_n`=0 and `sel_ba`=1, `bus_a` shows the B-to-A register.
- R10: With `oe_b`=1, `oe_a_n`=0 and both selects at 1, `bus_b` shows the A-to-B word and `bus_a` shows the B-to-A word at the same time.
- R11: With `oe_b`=1, `oe_a_n`=1, `sel_ab`=0 and A driven externally, one common rising edge of both clocks loads the A word into both registers.
- R12: With `oe_a_n`=0, `oe_b`=0, `sel_ba`=0 and B driven externally, one common rising edge of both clocks loads the B word into both registers.
- R13: With `oe_b`=1 and `sel_ab`=1, a common edge of both clocks loads the previous A-to-B word into the B-to-A register. A `clk_ab` edge followed by a later `clk_ba` edge loads the new A word into both.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ab | input | 1 | Rising-edge clock of the A-to-B register |
| clk_ba | input | 1 | Rising-edge clock of the B-to-A register |
| sel_ab | input | 1 | Source for B drive: 0 live A pins, 1 stored A-to-B word |
| sel_ba | input | 1 | Source for A drive: 0 live B pins, 1 stored B-to-A word |
| oe_b | input | 1 | B-side driver enable, active-high |
| oe_a_n | input | 1 | A-side driver enable, active-low |
| bus_a | inout | W | A bus pins |
| bus_b | inout | W | B bus pins |

## Verification
The two functions that share a cycle are register capture and output drive. When both clocks rise on one edge while one bus is driven from the other, the register on the driven side samples whatever the block itself is driving. The bench provokes this by raising both clocks in the same bench cycle: once with the live select (R11, R12), where both registers must end with the external word, and once with the stored select (R13), where the driven-side register must end with the old stored word. The reference model judges both cases by updating its stored words only from the pin values it computed before the edge.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
    typedef enum logic {
        SRC_LIVE   = 1'b0,
        SRC_STORED = 1'b1
    } src_e;
endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic [W-1:0] pins,
    output logic [W-1:0] word
);
    typedef struct packed {
        logic [W-1:0] word;
    } st_t;

    st_t st_d, st_q;

    // capture is unconditional on every edge
    always_comb begin
        st_d      = st_q;
        st_d.word = pins;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign word = st_q.word;
endmodule

// File: rtl/xcvr_side.sv
module xcvr_side #(
    parameter int W = 8
) (
    input  logic         en,
    input  logic         sel,
    input  logic [W-1:0] live,
    input  logic [W-1:0] stored,
    output logic         drive,
    output logic [W-1:0] value
);
    import xcvr_pkg::*;

    src_e src;

    always_comb begin
        src   = src_e'(sel);
        drive = en;
        value = (src == SRC_STORED) ? stored : live;
    end
endmodule

// File: rtl/dual_bus_xcvr.sv
module dual_bus_xcvr #(
    parameter int W = 8
) (
    input  logic         clk_ab,
    input  logic         clk_ba,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic         oe_b,
    input  logic         oe_a_n,
    inout  wire  [W-1:0] bus_a,
    inout  wire  [W-1:0] bus_b
);
    localparam int NSIDE = 2;

    logic [W-1:0] ab_word;
    logic [W-1:0] ba_word;
    logic [NSIDE-1:0] side_en;
    logic [NSIDE-1:0] side_drv;
    logic [W-1:0] side_val [NSIDE];

    assign side_en[0] = oe_b;
    assign side_en[1] = ~oe_a_n;

    xcvr_store #(.W(W)) u_store_ab (
        .clk  (clk_ab),
        .pins (bus_a),
        .word (ab_word)
    );

    xcvr_store #(.W(W)) u_store_ba (
        .clk  (clk_ba),
        .pins (bus_b),
        .word (ba_word)
    );

    // side 0 drives B, side 1 drives A
    xcvr_side #(.W(W)) u_side_b (
        .en     (side_en[0]),
        .sel    (sel_ab),
        .live   (bus_a),
        .stored (ab_word),
        .drive  (side_drv[0]),
        .value  (side_val[0])
    );

    xcvr_side #(.W(W)) u_side_a (
        .en     (side_en[1]),
        .sel    (sel_ba),
        .live   (bus_b),
        .stored (ba_word),
        .drive  (side_drv[1]),
        .value  (side_val[1])
    );

    assign bus_b = side_drv[0] ? side_val[0] : {W{1'bz}};
    assign bus_a = side_drv[1] ? side_val[1] : {W{1'bz}};
endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
    parameter int W = 8
) (
    input logic         clk_ab,
    input logic         clk_ba,
    input logic         sel_ab,
    input logic         sel_ba,
    input logic         oe_b,
    input logic         oe_a_n,
    input logic [W-1:0] bus_a,
    input logic [W-1:0] bus_b,
    input logic [W-1:0] ab_q,
    input logic [W-1:0] ba_q
);
    // R4
    ab_capture_chk: assert property (@(posedge clk_ab)
        1'b1 |=> ab_q === $past(bus_a));

    // R5
    ba_capture_chk: assert property (@(posedge clk_ba)
        1'b1 |=> ba_q === $past(bus_b));

    // R7
    b_stored_chk: assert property (@(posedge clk_ab)
        (oe_b && sel_ab) |-> bus_b === ab_q);

    // R9
    a_stored_chk: assert property (@(posedge clk_ba)
        (!oe_a_n && sel_ba) |-> bus_a === ba_q);

    // R6
    b_live_chk: assert property (@(posedge clk_ab)
        (oe_b && !sel_ab) |-> bus_b === bus_a);

    // R8
    a_live_chk: assert property (@(posedge clk_ba)
        (!oe_a_n && !sel_ba) |-> bus_a === bus_b);

    // R8
    no_loop_chk: assert property (@(posedge clk_ab)
        !(oe_b && !oe_a_n && !sel_ab && !sel_ba));
endmodule

bind dual_bus_xcvr xcvr_chk #(.W(W)) u_chk (
    .clk_ab (clk_ab),
    .clk_ba (clk_ba),
    .sel_ab (sel_ab),
    .sel_ba (sel_ba),
    .oe_b   (oe_b),
    .oe_a_n (oe_a_n),
    .bus_a  (bus_a),
    .bus_b  (bus_b),
    .ab_q   (ab_word),
    .ba_q   (ba_word)
);

// File: tb/dual_bus_xcvr_test.sv
module dual_bus_xcvr_test;
    localparam int W = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic pulse_ab = 1'b0, pulse_ba = 1'b0;
    logic sel_ab = 1'b1, sel_ba = 1'b1, oe_b = 1'b0, oe_a_n = 1'b1;
    logic a_en = 1'b1, b_en = 1'b1;
    logic [W-1:0] a_val = '0, b_val = '0;
    wire  [W-1:0] bus_a, bus_b;
    wire  clk_ab = clk & pulse_ab;
    wire  clk_ba = clk & pulse_ba;

    assign bus_a = a_en ? a_val : {W{1'bz}};
    assign bus_b = b_en ? b_val : {W{1'bz}};

    dual_bus_xcvr #(.W(W)) uut (
        .clk_ab (clk_ab),
        .clk_ba (clk_ba),
        .sel_ab (sel_ab),
        .sel_ba (sel_ba),
        .oe_b   (oe_b),
        .oe_a_n (oe_a_n),
        .bus_a  (bus_a),
        .bus_b  (bus_b)
    );

    int tests = 0, fails = 0;
    logic [W-1:0] m_ab = '0, m_ba = '0;

    task automatic check(input string tag, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // one bench cycle: set controls, compare pins, apply the edge to the model
    task automatic step(input logic ob, input logic oan, input logic sab,
                        input logic sba, input logic ae, input logic [W-1:0] av,
                        input logic be, input logic [W-1:0] bv,
                        input logic pab, input logic pba, input string tag);
        logic [W-1:0] ea, eb;
        @(negedge clk);
        oe_b = ob; oe_a_n = oan; sel_ab = sab; sel_ba = sba;
        a_en = ae; a_val = av; b_en = be; b_val = bv;
        pulse_ab = pab; pulse_ba = pba;
        #2;
        ea = av; eb = bv;
        if (ob && sab)    eb = m_ab;
        if (!oan && sba)  ea = m_ba;
        if (ob && !sab)   eb = ea;
        if (!oan && !sba) ea = eb;
        check(tag, "bus_a", bus_a, ea);
        check(tag, "bus_b", bus_b, eb);
        @(posedge clk);
        if (pab) m_ab = ea;
        if (pba) m_ba = eb;
    endtask

    initial begin
        // initial state: isolation, bench drives both buses (R3)
        step(0,1,1,1, 1,8'h00, 1,8'h00, 0,0, "R3");
        // load each register while isolated (R4, R5)
        step(0,1,1,1, 1,8'h3C, 1,8'h00, 1,0, "R4");
        step(0,1,1,1, 1,8'h00, 1,8'hA5, 0,1, "R5");
        // drivers off: bench values win although stored words differ (R1, R2, R3)
        step(0,1,1,1, 1,8'h00, 1,8'hFF, 0,0, "R1");
        step(0,1,1,1, 1,8'hFF, 1,8'h00, 0,0, "R2");
        // B from storage, then live (R7, R6)
        step(1,1,1,1, 1,8'h11, 0,8'h00, 0,0, "R7");
        step(1,1,0,1, 1,8'h5A, 0,8'h00, 0,0, "R6");
        step(1,1,0,1, 1,8'hC3, 0,8'h00, 0,0, "R6");
        // A from storage, then live (R9, R8)
        step(0,0,1,1, 0,8'h00, 1,8'h0F, 0,0, "R9");
        step(0,0,1,0, 0,8'h00, 1,8'h96, 0,0, "R8");
        step(0,0,1,0, 0,8'h00, 1,8'h69, 0,0, "R8");
        // swap: both buses from storage (R10)
        step(1,0,1,1, 0,8'h00, 0,8'h00, 0,0, "R10");
        // capture while driving out: A register still samples A pins (R4)
        step(1,0,1,1, 0,8'h00, 0,8'h00, 1,0, "R4");
        step(1,0,1,1, 0,8'h00, 0,8'h00, 0,0, "R4");
        // load both from A on one edge, then show by swap (R11)
        step(1,1,0,1, 1,8'h77, 0,8'h00, 1,1, "R11");
        step(1,0,1,1, 0,8'h00, 0,8'h00, 0,0, "R11");
        check("R11", "model ab", m_ab, 8'h77);
        check("R11", "model ba", m_ba, 8'h77);
        // load both from B on one edge (R12)
        step(0,0,1,0, 0,8'h00, 1,8'hE1, 1,1, "R12");
        step(1,0,1,1, 0,8'h00, 0,8'h00, 0,0, "R12");
        // stored select with a common edge: B-to-A gets the old word (R13)
        step(1,1,1,1, 1,8'h24, 0,8'h00, 1,1, "R13");
        step(1,0,1,1, 0,8'h00, 0,8'h00, 0,0, "R13");
        check("R13", "model ba", m_ba, 8'hE1);
        // staggered edges load the new word into both (R13)
        step(1,1,1,1, 1,8'h42, 0,8'h00, 1,0, "R13");
        step(1,1,1,1, 1,8'h42, 0,8'h00, 0,1, "R13");
        step(1,0,1,1, 0,8'h00, 0,8'h00, 0,0, "R13");
        // isolation with no clocks keeps both words (R3)
        step(0,1,1,1, 1,8'h81, 1,8'h18, 0,0, "R3");
        step(1,0,1,1, 0,8'h00, 0,8'h00, 0,0, "R3");
        @(negedge clk);
        pulse_ab = 1'b0; pulse_ba = 1'b0;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule